// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block drives the transmit side of one RMII port at 100 Mb/s. A client hands it payload bytes over a valid/ready handshake, with a flag that marks the final byte of the frame. The block builds the preamble and start-of-frame delimiter itself, then serializes every byte into four dibits on `txd_o`, least significant pair first. `txen_o` frames the whole burst, and both change only on the rising edge of the 50 MHz reference clock.

The frame check sequence and any padding are the client's job: they arrive as ordinary payload bytes. After each frame the block holds the line idle for the 96-bit inter-frame gap before it accepts the next frame. If the client fails to supply a byte when one is due, the block closes the frame at the next byte boundary and reports the underrun.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While `rst_ni` is low, `txen_o` is 0, `txd_o` is 00, `ready_o` is 0 and `underrun_o` is 0.
- R2: In idle with the gap satisfied, a high `valid_i` starts a frame, and `txen_o` rises on the next clock edge. The first byte stays on `data_i` and is not taken until the preamble has been sent. While `valid_i` is low in idle, `txen_o` stays low.
- R3: A frame opens with 32 dibits: 28 dibits of 01 (seven bytes of 0x55), then 01, 01, 01, 11 (the byte 0xD5, lowest pair first).
- R4: Whenever `txen_o` is low, `txd_o` is 00.
- R5: Each payload byte goes out as four consecutive dibits, bits [1:0] first and bits [7:6] last. `ready_o` is high only in the cycle that carries the last dibit of the delimiter or of a payload byte not flagged last. It is never high on two consecutive cycles, and never while `txen_o` is low. A byte is taken on an edge where `valid_i` and `ready_o` are both high.
- R6: After the byte taken with `last_i` high, `txen_o` falls on the edge right after that byte's fourth dibit, so `txen_o` is high for exactly 32 + 4N cycles for N bytes.
- R7: If `valid_i` is low while `ready_o` is high, the frame ends after the current dibit, and `underrun_o` is high for exactly the first cycle in which `txen_o` is low. `underrun_o` is not raised for any other reason.
- R8: Between frames, `txen_o` stays low for at least 48 cycles. With `valid_i` held high, the gap is exactly 48 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Payload byte |
| valid_i | input | 1 | Payload byte valid |
| last_i | input | 1 | Marks the final byte of the frame |
| ready_o | output | 1 | Block takes `data_i` on this edge |
| txen_o | output | 1 | Transmit enable to the PHY |
| txd_o | output | 2 | Transmit dibit to the PHY |
| underrun_o | output | 1 | One-cycle pulse when a frame is cut short |

## Verification
Four properties are checked by assertions on every cycle:
- the line is quiet whenever transmit is disabled;
- `ready_o` is spaced and is only asserted during transmission;
- the underrun pulse has the right shape and position;
- every transmit burst is a whole number of bytes of at least 32 dibits, and no burst begins before 48 low cycles.

Some properties can only be shown by the bench's scenarios. These are the exact dibit contents of the preamble and payload, the position of the end relative to the final byte, the exact gap length under back-to-back traffic, and underrun at the delimiter and mid-payload.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_PAY, ST_GAP} tx_state_e;
  typedef enum logic [1:0] {SRC_PRE, SRC_SFD, SRC_DATA} byte_src_e;
  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/rmii_tx_gap_timer.sv
module rmii_tx_gap_timer #(
  parameter int GAP_CYCLES = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_gap_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(GAP_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // Gap state lasts GAP_CYCLES-1 cycles; the mandatory idle cycle makes up the rest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!in_gap_i) cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = in_gap_i && (cnt_q == CNT_W'(GAP_CYCLES - 2));
endmodule

// File: rtl/rmii_tx_shifter.sv
module rmii_tx_shifter
  import rmii_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  byte_src_e src_i,
  input  logic [7:0] data_i,
  output logic [1:0] txd_o
);
  logic [7:0] sr_q;
  logic [7:0] byte_d;

  always_comb begin
    unique case (src_i)
      SRC_PRE: byte_d = PRE_BYTE;
      SRC_SFD: byte_d = SFD_BYTE;
      default: byte_d = data_i;
    endcase
  end

  // Shifting in zeros drains to 00 after the last dibit of a byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= byte_d;
    else             sr_q <= {2'b00, sr_q[7:2]};
  end

  assign txd_o = sr_q[1:0];
endmodule

// File: rtl/rmii_tx_fsm.sv
module rmii_tx_fsm
  import rmii_tx_pkg::*;
#(
  parameter int PRE_BYTES = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      last_i,
  input  logic      gap_done_i,
  output logic      txen_o,
  output logic      ready_o,
  output logic      load_o,
  output byte_src_e src_o,
  output logic      in_gap_o,
  output logic      underrun_o
);
  localparam int PB_W = $clog2(PRE_BYTES);
  localparam logic [PB_W-1:0] PB_LAST = PB_W'(PRE_BYTES - 1);
  localparam logic [PB_W-1:0] PB_SFD  = PB_W'(PRE_BYTES - 2);

  tx_state_e       state_q;
  logic [PB_W-1:0] byte_q;
  logic [1:0]      dib_q;
  logic            last_q;
  logic            und_q;
  logic            last_dib, need_byte, start;

  assign last_dib  = (dib_q == 2'd3);
  assign need_byte = last_dib && (((state_q == ST_PRE) && (byte_q == PB_LAST)) ||
                                  ((state_q == ST_PAY) && !last_q));
  assign start     = (state_q == ST_IDLE) && valid_i;

  assign ready_o    = need_byte;
  assign txen_o     = (state_q == ST_PRE) || (state_q == ST_PAY);
  assign in_gap_o   = (state_q == ST_GAP);
  assign underrun_o = und_q;

  always_comb begin
    load_o = 1'b0;
    src_o  = SRC_DATA;
    if (start) begin
      load_o = 1'b1;
      src_o  = SRC_PRE;
    end else if ((state_q == ST_PRE) && last_dib && (byte_q != PB_LAST)) begin
      load_o = 1'b1;
      src_o  = (byte_q == PB_SFD) ? SRC_SFD : SRC_PRE;
    end else if (need_byte && valid_i) begin
      load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      dib_q   <= '0;
      last_q  <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      und_q <= need_byte && !valid_i;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_PRE;
          byte_q  <= '0;
          dib_q   <= '0;
        end
        ST_PRE: begin
          dib_q <= dib_q + 2'd1;
          if (last_dib) begin
            if (byte_q != PB_LAST) byte_q <= byte_q + 1'b1;
            else if (valid_i) begin
              state_q <= ST_PAY;
              last_q  <= last_i;
            end else state_q <= ST_GAP;
          end
        end
        ST_PAY: begin
          dib_q <= dib_q + 2'd1;
          if (last_dib) begin
            if (last_q)       state_q <= ST_GAP;
            else if (valid_i) last_q  <= last_i;
            else              state_q <= ST_GAP;
          end
        end
        default: if (gap_done_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ready_spaced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_ready_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> txen_o);
  assert_underrun_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
  assert_underrun_after_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (!txen_o && $fell(txen_o)));
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
#(
  parameter int PRE_BYTES  = 8,
  parameter int GAP_CYCLES = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       txen_o,
  output logic [1:0] txd_o,
  output logic       underrun_o
);
  localparam int LOW_W = $clog2(GAP_CYCLES + 1);
  localparam int RUN_W = 16;
  localparam int MIN_RUN = 4 * PRE_BYTES;

  logic      load, in_gap, gap_done;
  byte_src_e src;

  rmii_tx_fsm #(.PRE_BYTES(PRE_BYTES)) u_fsm (
    .clk_i, .rst_ni, .valid_i, .last_i,
    .gap_done_i (gap_done),
    .txen_o, .ready_o,
    .load_o     (load),
    .src_o      (src),
    .in_gap_o   (in_gap),
    .underrun_o
  );

  rmii_tx_shifter u_shift (
    .clk_i, .rst_ni,
    .load_i (load),
    .src_i  (src),
    .data_i,
    .txd_o
  );

  rmii_tx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i, .rst_ni,
    .in_gap_i (in_gap),
    .done_o   (gap_done)
  );

  // Observation counters for the line-level properties
  logic [LOW_W-1:0] low_cnt_q;
  logic [RUN_W-1:0] run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= LOW_W'(GAP_CYCLES);
      run_cnt_q <= '0;
    end else begin
      if (txen_o) low_cnt_q <= '0;
      else if (low_cnt_q != LOW_W'(GAP_CYCLES)) low_cnt_q <= low_cnt_q + 1'b1;
      if (!txen_o) run_cnt_q <= '0;
      else if (run_cnt_q != '1) run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  assert_txd_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txen_o |-> (txd_o == 2'b00));
  assert_ifg_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> (low_cnt_q == LOW_W'(GAP_CYCLES)));
  assert_whole_bytes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txen_o) |-> ((run_cnt_q[1:0] == 2'b00) && (run_cnt_q >= RUN_W'(MIN_RUN))));
endmodule

// File: tb/tb_rmii_tx_serializer.sv
module tb_rmii_tx_serializer;
  localparam int WATCHDOG = 20000;
  localparam int NB = 16;
  localparam logic [7:0] BYTES [NB] = '{8'hA7, 8'h00, 8'hFF, 8'h1B, 8'hE4,
                                       8'h3C, 8'h81, 8'h5A, 8'hC3, 8'h96, 8'h0F,
                                       8'h72, 8'hD5, 8'h55, 8'h69, 8'hB8};
  localparam int NF = 5;
  // frame table: start index, length, underrun point (-1 none), expect gap check
  localparam int FR_ST  [NF] = '{0, 1, 5, 11, 0};
  localparam int FR_LEN [NF] = '{1, 4, 6, 5, 3};
  localparam int FR_UND [NF] = '{-1, -1, -1, 2, 0};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic valid_i = 1'b0;
  logic last_i = 1'b0;
  logic ready_o, txen_o, underrun_o;
  logic [1:0] txd_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  rmii_tx_serializer dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_dibit(input int st, input int j);
    if (j < 31) return 1;
    if (j == 31) return 3;
    return int'((BYTES[st + (j - 32) / 4] >> (2 * ((j - 32) % 4))) & 8'h03);
  endfunction

  task automatic run_frame(input int st, input int len, input int und, output int pre_low);
    int idx = 0;
    int n = 0;
    bit started = 0;
    bit hs = 0;
    int err_idle = 0, err_rdy = 0, err_und = 0, err_pre = 0, err_pay = 0;
    int exp_n, exp_und;
    logic [1:0] cap [0:127];
    pre_low = 0;
    valid_i = 1'b1; data_i = BYTES[st]; last_i = (len == 1);
    forever begin
      @(negedge clk_i);
      if (hs) begin
        idx++;
        if (idx >= len) begin valid_i = 1'b0; last_i = 1'b0; end
        else begin data_i = BYTES[st + idx]; last_i = (idx == len - 1); end
      end
      if (started && idx == und) valid_i = 1'b0;
      if (!txen_o && ready_o) err_rdy++;
      if (txen_o) begin
        if (n < 128) cap[n] = txd_o;
        n++; started = 1;
        if (underrun_o) err_und++;
      end else if (started) break;
      else begin
        pre_low++;
        if (txd_o != 2'b00) err_idle++;
      end
      hs = ready_o && valid_i;
    end
    exp_n = 32 + 4 * ((und >= 0) ? und : len);
    exp_und = (und >= 0) ? 1 : 0;
    for (int j = 0; j < n && j < 128; j++) begin
      if (j < 32) begin if (int'(cap[j]) != exp_dibit(st, j)) err_pre++; end
      else if (j < exp_n && int'(cap[j]) != exp_dibit(st, j)) err_pay++;
    end
    chk(n == exp_n, "R6 txen high cycles", n, exp_n);
    chk(err_pre == 0, "R3 preamble dibits mismatches", err_pre, 0);
    chk(err_pay == 0, "R5 payload dibits mismatches", err_pay, 0);
    chk(err_rdy == 0, "R5 ready while txen low", err_rdy, 0);
    chk(int'(underrun_o) == exp_und, "R7 underrun at frame end", underrun_o, exp_und);
    chk(err_und == 0, "R7 underrun during frame", err_und, 0);
    chk(txd_o == 2'b00 && err_idle == 0, "R4 txd idle", err_idle + int'(txd_o), 0);
    valid_i = 1'b0; last_i = 1'b0;
  endtask

  initial begin
    int pl;
    int hi;
    repeat (3) @(negedge clk_i);
    chk(!txen_o && txd_o == 2'b00, "R1 reset txen/txd", {txen_o, txd_o}, 0);
    chk(!ready_o && !underrun_o, "R1 reset ready/underrun", {ready_o, underrun_o}, 0);
    rst_ni = 1'b1;

    // table walk, frames back to back
    for (int f = 0; f < NF; f++) begin
      run_frame(FR_ST[f], FR_LEN[f], FR_UND[f], pl);
      if (f == 0) chk(pl == 0, "R2 txen rises edge after valid", pl, 0);
      else chk(pl + 1 == 48, "R8 back-to-back gap", pl + 1, 48);
    end

    // valid low in idle: no frame
    hi = 0;
    repeat (80) begin
      @(negedge clk_i);
      if (txen_o) hi++;
    end
    chk(hi == 0, "R2 no frame without valid", hi, 0);

    // late request after long idle still starts on next edge
    run_frame(7, 2, -1, pl);
    chk(pl == 0, "R2 start after long idle", pl, 0);

    // reset mid-frame
    valid_i = 1'b1; data_i = 8'h3C; last_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!txen_o && txd_o == 2'b00 && !ready_o && !underrun_o, "R1 reset mid-frame",
        {txen_o, txd_o, ready_o, underrun_o}, 0);
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    run_frame(12, 4, -1, pl);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule